// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block shifts a 32-bit two's-complement operand by a signed count in one registered pipeline stage. The count is a signed value held in the low half of a 32-bit count word. A count above zero moves the operand toward the most significant end and fills with zeros. A count below zero moves it toward the least significant end and copies the sign bit into the vacated positions.

A left shift can push significant bits out of the word. The block detects this and raises an overflow flag. When the saturate input is high, an overflowing left shift is clamped to the largest positive or most negative value, chosen by the operand's sign. When saturate is low, the shifted value simply wraps.

The result and the flag are captured on a clock edge whenever the input valid is high. An output valid marks them one cycle later. A surrounding execution unit presents one operation per cycle and reads the result on the following cycle.

Top module: `sat_shift_unit`

## Requirements
- R1: The shift count is the signed 16-bit value in bits [15:0] of `countWord`. Bits [31:16] have no effect on the result or the flag.
- R2: A count n with 0 < n < 32 produces the operand moved left by n places with zeros in the low n bits, provided no overflow is flagged. A count of 0 returns the operand unchanged with no overflow.
- R3: A count -n with n > 0 produces an arithmetic right shift: the sign bit is replicated into the upper n places and bits leaving the bottom are discarded. Right shifts never raise `ovf` and are never clamped.
- R4: For a left shift by n, `ovf` is 1 exactly when the top n+1 bits of the operand are not all equal to its sign bit. The flag does not depend on `satEn`.
- R5: With `satEn` = 1, an overflowing left shift of a non-negative operand yields 0x7FFFFFFF.
- R6: With `satEn` = 1, an overflowing left shift of a negative operand yields 0x80000000.
- R7: With `satEn` = 0, an overflowing left shift yields the plain truncated shift result, and `ovf` is still 1.
- R8: A left shift that loses no significant bit is not clamped, even when `satEn` = 1.
- R9: A count of +32 or more yields 0 before saturation, and flags overflow for every nonzero operand. A count of -32 or less yields all copies of the sign bit.
- R10: `outValid` is 1 in the cycle after a cycle with `inValid` = 1 and 0 otherwise. `result` and `ovf` belong to the operation presented one cycle earlier.
- R11: Synchronous reset drives `outValid`, `result` and `ovf` to 0.
- R12: In a cycle with `inValid` = 0, the next `result` and `ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | An operation is presented this cycle |
| dataIn | input | 32 | Operand to be shifted |
| countWord | input | 32 | Count word; signed count in bits [15:0] |
| satEn | input | 1 | Clamp overflowing left shifts when 1 |
| result | output | 32 | Registered shift result |
| ovf | output | 1 | Registered left-shift overflow flag |
| outValid | output | 1 | `result` and `ovf` hold a new operation |

## Verification
The bench builds the block with its default widths: a 32-bit operand and a 16-bit count field. With a count field that wide, counts far beyond ±32 can be applied, so the out-of-range left and right cases of R9 are exercised alongside the ±31 edges. The vector walk runs back to back, so the one-cycle latency and the valid pairing are checked under full throughput. Directed steps then cover idle hold and reset.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  // Strobes issued by the control half to the datapath each cycle
  typedef struct packed {
    logic clear;    // return stored result and flag to zero
    logic capture;  // load the newly computed result and flag
  } shiftStrobe_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import sat_shift_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output shiftStrobe_t strobe,
  output logic         outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import sat_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  shiftStrobe_t      strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  countField,
  input  logic              satEn,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic              goRight;
  logic [CNT_W-1:0]  shiftMag;
  logic [DATA_W-1:0] leftRaw;
  logic [DATA_W-1:0] rightRaw;
  logic [DATA_W-1:0] leftBack;
  logic              leftLost;
  logic [DATA_W-1:0] satValue;
  logic [DATA_W-1:0] nextResult;
  logic              nextOvf;

  always_comb begin
    goRight  = countField[CNT_W-1];
    // unsigned magnitude; the most negative count maps to 2**(CNT_W-1)
    shiftMag = goRight ? (~countField + 1'b1) : countField;
    leftRaw  = dataIn << shiftMag;
    rightRaw = DATA_W'($signed(dataIn) >>> shiftMag);
    // shifting back and comparing exposes any lost significant bit;
    // for magnitudes >= DATA_W this reduces to "operand is nonzero"
    leftBack = DATA_W'($signed(leftRaw) >>> shiftMag);
    leftLost = (leftBack != dataIn);
    satValue = dataIn[DATA_W-1] ? MAX_NEG : MAX_POS;

    if (goRight) begin
      nextResult = rightRaw;
      nextOvf    = 1'b0;
    end else begin
      nextResult = (leftLost && satEn) ? satValue : leftRaw;
      nextOvf    = leftLost;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      result <= '0;
      ovf    <= 1'b0;
    end else if (strobe.capture) begin
      result <= nextResult;
      ovf    <= nextOvf;
    end
  end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
  import sat_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] countWord,
  input  logic              satEn,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              outValid
);
  shiftStrobe_t strobe;
  logic         unusedCountHi;

  assign unusedCountHi = ^countWord[DATA_W-1:CNT_W];

  shift_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  shift_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .dataIn     (dataIn),
    .countField (countWord[CNT_W-1:0]),
    .satEn      (satEn),
    .result     (result),
    .ovf        (ovf)
  );
endmodule

// File: rtl/sat_shift_checker.sv
module sat_shift_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] countWord,
  input logic              satEn,
  input logic [DATA_W-1:0] result,
  input logic              ovf,
  input logic              outValid
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!outValid && !ovf && result == '0)); // R11
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R10
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !inValid |=> !outValid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !inValid |=> ($stable(result) && $stable(ovf))); // R12
  AST_RIGHT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (inValid && countWord[CNT_W-1]) |=> !ovf); // R3
  AST_SAT_POSITIVE: assert property (@(posedge clk) disable iff (rst) (inValid && satEn && !dataIn[DATA_W-1]) |=> (!ovf || result == MAX_POS)); // R5
  AST_SAT_NEGATIVE: assert property (@(posedge clk) disable iff (rst) (inValid && satEn && dataIn[DATA_W-1]) |=> (!ovf || result == MAX_NEG)); // R6
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst) (inValid && countWord[CNT_W-1:0] == '0) |=> (!ovf && result == $past(dataIn))); // R2
endmodule

bind sat_shift_unit sat_shift_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .dataIn    (dataIn),
  .countWord (countWord),
  .satEn     (satEn),
  .result    (result),
  .ovf       (ovf),
  .outValid  (outValid)
);

// File: tb/sim_sat_shift_unit.sv
`timescale 1ns/1ps
module sim_sat_shift_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] dataIn;
  logic [31:0] countWord;
  logic        satEn;
  logic [31:0] result;
  logic        ovf;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sat_shift_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .countWord(countWord), .satEn(satEn), .result(result),
    .ovf(ovf), .outValid(outValid)
  );

  // {operand, count word, saturate, expected result, expected flag}
  localparam int NV = 28;
  localparam logic [97:0] VEC [NV] = '{
    {32'h01230001, 32'h01230001, 1'b1, 32'h02460002, 1'b0}, // R1 R2 upper half ignored
    {32'h12345678, 32'h00000001, 1'b1, 32'h2468ACF0, 1'b0}, // R2
    {32'h12345678, 32'h00000005, 1'b1, 32'h7FFFFFFF, 1'b1}, // R5 R4
    {32'h01230002, 32'h00000005, 1'b1, 32'h24600040, 1'b0}, // R8
    {32'h0000000E, 32'h0000000E, 1'b1, 32'h00038000, 1'b0}, // R8
    {32'h01230002, 32'h0000000E, 1'b1, 32'h7FFFFFFF, 1'b1}, // R5
    {32'h82345678, 32'h0000FFFA, 1'b1, 32'hFE08D159, 1'b0}, // R3
    {32'hB56789AB, 32'h0000FFF2, 1'b1, 32'hFFFED59E, 1'b0}, // R3
    {32'h3456789A, 32'h0000FFF1, 1'b1, 32'h000068AC, 1'b0}, // R3
    {32'h456789AB, 32'hABCDFFFF, 1'b0, 32'h22B3C4D5, 1'b0}, // R1 R3
    {32'h12345678, 32'h00000005, 1'b0, 32'h468ACF00, 1'b1}, // R7 R4
    {32'h80000001, 32'h00000001, 1'b1, 32'h80000000, 1'b1}, // R6
    {32'h80000001, 32'h00000001, 1'b0, 32'h00000002, 1'b1}, // R7
    {32'hFFFFFFF0, 32'h00000004, 1'b1, 32'hFFFFFF00, 1'b0}, // R4 R8 negative kept
    {32'hC0000000, 32'h00000001, 1'b1, 32'h80000000, 1'b0}, // R4 boundary no overflow
    {32'h40000000, 32'h00000001, 1'b1, 32'h7FFFFFFF, 1'b1}, // R4 R5 sign change
    {32'h00000001, 32'h0000001F, 1'b0, 32'h80000000, 1'b1}, // R7 count 31
    {32'h00000001, 32'h0000001F, 1'b1, 32'h7FFFFFFF, 1'b1}, // R5 count 31
    {32'h00000001, 32'h00000020, 1'b0, 32'h00000000, 1'b1}, // R9 left 32
    {32'hF0000000, 32'h00000020, 1'b1, 32'h80000000, 1'b1}, // R9 R6 left 32
    {32'h00000000, 32'h00000020, 1'b1, 32'h00000000, 1'b0}, // R9 zero operand
    {32'h80000000, 32'h0000FFE0, 1'b1, 32'hFFFFFFFF, 1'b0}, // R9 right 32
    {32'h7FFFFFFF, 32'h0000FFE0, 1'b1, 32'h00000000, 1'b0}, // R9 right 32
    {32'h80000000, 32'h0000FFE1, 1'b0, 32'hFFFFFFFF, 1'b0}, // R3 right 31
    {32'h7FFFFFFF, 32'h0000FFE1, 1'b0, 32'h00000000, 1'b0}, // R3 right 31
    {32'h80000000, 32'h00008000, 1'b1, 32'hFFFFFFFF, 1'b0}, // R9 most negative count
    {32'h80000000, 32'hFFFF0000, 1'b1, 32'h80000000, 1'b0}, // R2 R1 zero count
    {32'h12345678, 32'h00007FFF, 1'b0, 32'h00000000, 1'b1}  // R9 huge left
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; dataIn = '0; countWord = '0; satEn = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({31'b0, outValid}, 32'd0, "R11 outValid after reset");
    check(result, 32'd0, "R11 result after reset");
    check({31'b0, ovf}, 32'd0, "R11 ovf after reset");
    rst = 1'b0;

    // Back-to-back walk of the vector table (R10 at full throughput)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check({31'b0, outValid}, 32'd1, $sformatf("R10 outValid vec %0d", i-1));
        check(result, VEC[i-1][32:1], $sformatf("R1-table result vec %0d", i-1));
        check({31'b0, ovf}, {31'b0, VEC[i-1][0]}, $sformatf("R4 ovf vec %0d", i-1));
      end
      if (i < NV) begin
        inValid   = 1'b1;
        dataIn    = VEC[i][97:66];
        countWord = VEC[i][65:34];
        satEn     = VEC[i][33];
      end else begin
        inValid = 1'b0;
      end
    end

    // R12: idle cycles keep the last result; R10: no valid while idle
    dataIn = 32'h40000000; countWord = 32'h00000003; satEn = 1'b1;
    @(negedge clk);
    check({31'b0, outValid}, 32'd0, "R10 outValid idle");
    check(result, 32'h00000000, "R12 result held");
    check({31'b0, ovf}, 32'd1, "R12 ovf held");

    // R1: only upper half differs between two operations
    inValid = 1'b1; dataIn = 32'h00000003; countWord = 32'hFFFF0002; satEn = 1'b0;
    @(negedge clk);
    countWord = 32'h12340002;
    @(negedge clk);
    inValid = 1'b0;
    check(result, 32'h0000000C, "R1 upper half variant");
    @(negedge clk);
    check(result, 32'h0000000C, "R1 upper half second variant");

    // R11: reset in the middle of activity
    inValid = 1'b1; dataIn = 32'h00000005; countWord = 32'h00000001;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({31'b0, outValid}, 32'd0, "R11 outValid mid-run reset");
    check(result, 32'd0, "R11 result mid-run reset");
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);
    check({31'b0, outValid}, 32'd0, "R10 idle after reset");

    finish_run();
  end
endmodule